// File: doc/BRIEF.md
# Interrupt and Exception Entry Controller

This block decides when a pipelined core must leave its instruction stream to service an event, and it sequences the entry into the service routine. It accepts three kinds of event. The first is a set of exception sources, each with a mask bit. The second is a single fast interrupt line. The third is a vector of normal interrupt lines. An event that wins arbitration freezes the pipeline. The block then waits until the core reports that all older instructions have retired. After that it issues a one-cycle redirect to the service routine address and latches the return address.

The fast interrupt always enters at one fixed address. All normal interrupt lines share a single dispatcher address. For normal interrupts the block reports the line being served, so the dispatcher can find the real source. Each unmasked exception enters at its own slot in an exception table. It also sends a notify pulse to an external host or debug unit, and the pipeline stays frozen until that unit returns a resume command. Exception sources whose mask bit is set are dropped without trace. Requests that arrive while an entry is in progress are kept pending and served afterwards.

The control is a five-state machine:
- **IDLE**: no entry in progress.
- **FREEZE**: the first frozen cycle.
- **DRAIN**: waits for the drained indication.
- **REDIRECT**: a single cycle that issues the redirect.
- **WAIT_CMD**: exceptions only; waits for the resume command.

The transitions are:
- IDLE→FREEZE when any request is selected.
- FREEZE→DRAIN unconditionally.
- DRAIN→REDIRECT when drained is seen.
- REDIRECT→IDLE for interrupts.
- REDIRECT→WAIT_CMD for exceptions.
- WAIT_CMD→IDLE on resume.

Top module: `intr_exc_ctrl`

## Requirements
- R1: After reset, `freeze`, `busy`, `redirect_valid`, `fiq_ack`, `irq_ack` and `exc_notify` are all low.
- R2: When several requests are eligible in the same IDLE cycle, an unmasked exception is served first, then the fast interrupt, then normal interrupts.
- R3: A fast interrupt redirects to `FIQ_VEC` (default 0x100) and raises `fiq_ack` for the redirect cycle only.
- R4: A normal interrupt redirects to `IRQ_VEC` (default 0x200) and raises `irq_ack`. `irq_id` gives the lowest-numbered pending line, and only that line's pending flag is cleared.
- R5: If `pipe_drained` is already high, `redirect_valid` is high in the cycle after the third rising edge counted from the edge that samples the request. The handler's first fetch is then on the fourth edge. Each cycle that `pipe_drained` stays low in DRAIN adds one cycle.
- R6: `freeze` is high from the cycle after a request is accepted through the redirect cycle. `busy` is high while an entry is in progress or any request is pending.
- R7: An exception source whose mask bit is 1 in the same cycle is ignored. It causes no freeze, no notify and no later entry.
- R8: Unmasked exception number k redirects to `EXC_BASE + (k << EXC_SHIFT)` (defaults 0x400 and 4). It pulses `exc_notify` with `exc_code = k` in the redirect cycle. `freeze` then stays high until `host_resume` is sampled, and `busy` is low in the next cycle if nothing else is pending.
- R9: A request that arrives while an entry is in progress is held and served by a later entry.
- R10: `ret_addr` is valid from the redirect cycle on. It holds `resume_pc` for an interrupt, sampled on the edge that enters REDIRECT. For an exception it holds `fault_pc`, sampled when the exception arrived.
- R11: `redirect_valid` is a single-cycle pulse. It only follows a cycle in which `pipe_drained` was sampled high in DRAIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | NIRQ | Normal interrupt request lines |
| exc_src | input | NEXC | Exception source pulses |
| exc_mask | input | NEXC | 1 = matching exception source is ignored |
| pipe_drained | input | 1 | All instructions older than the stop point have retired |
| resume_pc | input | PCW | PC at which an interrupted stream resumes |
| fault_pc | input | PCW | PC of the instruction raising an exception |
| host_resume | input | 1 | Resolving command from the host or debug unit |
| freeze | output | 1 | Stall the pipeline |
| busy | output | 1 | Entry in progress or request pending |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | PCW | Service routine address |
| ret_addr | output | PCW | Latched return address |
| fiq_ack | output | 1 | Fast interrupt accepted |
| irq_ack | output | 1 | Normal interrupt accepted |
| irq_id | output | IRQ_IW | Line number being served |
| exc_notify | output | 1 | Exception notification pulse |
| exc_code | output | EXC_IW | Exception number being served |

## Verification
The bench goes after simultaneous requests. A design with the wrong priority would redirect to the wrong vector first, or would lose the loser instead of serving it on the next entry. It pulses a normal interrupt while a fast interrupt entry is already frozen, and raises two normal interrupt lines at once. A controller that cleared all pending state on acknowledge would never make the second entry. It varies the drain delay and expects the redirect exactly three cycles after the request plus the delay, so an off-by-one in DRAIN shows up as a latency error. It mixes a masked and an unmasked exception in one cycle. A controller that latched masked bits would make a second entry after resume.

// File: rtl/iec_pkg.sv
package iec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREEZE,
        ST_DRAIN,
        ST_REDIRECT,
        ST_WAIT_CMD
    } iec_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE,
        CAUSE_EXC,
        CAUSE_FIQ,
        CAUSE_IRQ
    } iec_cause_e;

endpackage

// File: rtl/iec_lowest.sv
module iec_lowest #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/iec_pending.sv
module iec_pending #(
    parameter int NIRQ = 4,
    parameter int NEXC = 4,
    parameter int PCW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fiq_req,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NEXC-1:0] exc_src,
    input  logic [NEXC-1:0] exc_mask,
    input  logic [PCW-1:0]  fault_pc,
    input  logic            fiq_clr,
    input  logic [NIRQ-1:0] irq_clr,
    input  logic [NEXC-1:0] exc_clr,
    output logic            fiq_eff,
    output logic [NIRQ-1:0] irq_eff,
    output logic [NEXC-1:0] exc_eff,
    output logic [PCW-1:0]  fault_pc_q
);
    logic            fiq_pend_q;
    logic [NIRQ-1:0] irq_pend_q;
    logic [NEXC-1:0] exc_pend_q;
    logic [NEXC-1:0] exc_new;

    // Masking is applied on arrival, so a masked source never reaches a flag.
    assign exc_new = exc_src & ~exc_mask;
    assign fiq_eff = fiq_pend_q | fiq_req;
    assign irq_eff = irq_pend_q | irq_req;
    assign exc_eff = exc_pend_q | exc_new;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fiq_pend_q <= 1'b0;
        end else begin
            fiq_pend_q <= (fiq_pend_q & ~fiq_clr) | fiq_req;
        end
    end

    for (genvar i = 0; i < NIRQ; i++) begin : g_irq
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_pend_q[i] <= 1'b0;
            end else begin
                irq_pend_q[i] <= (irq_pend_q[i] & ~irq_clr[i]) | irq_req[i];
            end
        end

        // R9
        irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_pend_q[i] && !irq_clr[i]) |=> irq_pend_q[i]);
    end

    for (genvar j = 0; j < NEXC; j++) begin : g_exc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                exc_pend_q[j] <= 1'b0;
            end else begin
                exc_pend_q[j] <= (exc_pend_q[j] & ~exc_clr[j]) | exc_new[j];
            end
        end

        // R7
        masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (exc_mask[j] && !exc_pend_q[j]) |=> !exc_pend_q[j]);
    end

    // The faulting PC is taken when an exception arrives with none pending.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_pc_q <= '0;
        end else if (|exc_new && !(|exc_pend_q)) begin
            fault_pc_q <= fault_pc;
        end
    end
endmodule

// File: rtl/iec_select.sv
module iec_select
    import iec_pkg::*;
#(
    parameter int NIRQ   = 4,
    parameter int NEXC   = 4,
    parameter int IRQ_IW = 2,
    parameter int EXC_IW = 2
) (
    input  logic              fiq_eff,
    input  logic [NIRQ-1:0]   irq_eff,
    input  logic [NEXC-1:0]   exc_eff,
    output iec_cause_e        cause,
    output logic [IRQ_IW-1:0] irq_idx,
    output logic [EXC_IW-1:0] exc_idx
);
    logic irq_hit;
    logic exc_hit;

    iec_lowest #(.N(NIRQ), .IW(IRQ_IW)) u_irq_pick (
        .vec (irq_eff),
        .hit (irq_hit),
        .idx (irq_idx)
    );

    iec_lowest #(.N(NEXC), .IW(EXC_IW)) u_exc_pick (
        .vec (exc_eff),
        .hit (exc_hit),
        .idx (exc_idx)
    );

    // Fixed order: exception, then fast interrupt, then normal interrupt.
    always_comb begin
        if (exc_hit) begin
            cause = CAUSE_EXC;
        end else if (fiq_eff) begin
            cause = CAUSE_FIQ;
        end else if (irq_hit) begin
            cause = CAUSE_IRQ;
        end else begin
            cause = CAUSE_NONE;
        end
    end
endmodule

// File: rtl/iec_vector.sv
module iec_vector
    import iec_pkg::*;
#(
    parameter int             PCW       = 32,
    parameter int             EXC_IW    = 2,
    parameter logic [PCW-1:0] FIQ_VEC   = 32'h0000_0100,
    parameter logic [PCW-1:0] IRQ_VEC   = 32'h0000_0200,
    parameter logic [PCW-1:0] EXC_BASE  = 32'h0000_0400,
    parameter int             EXC_SHIFT = 4
) (
    input  iec_cause_e        cause,
    input  logic [EXC_IW-1:0] exc_idx,
    output logic [PCW-1:0]    target
);
    always_comb begin
        unique case (cause)
            CAUSE_EXC:  target = EXC_BASE + (PCW'(exc_idx) << EXC_SHIFT);
            CAUSE_FIQ:  target = FIQ_VEC;
            CAUSE_IRQ:  target = IRQ_VEC;
            CAUSE_NONE: target = '0;
            default:    target = '0;
        endcase
    end
endmodule

// File: rtl/intr_exc_ctrl.sv
module intr_exc_ctrl
    import iec_pkg::*;
#(
    parameter int             NIRQ      = 4,
    parameter int             NEXC      = 4,
    parameter int             PCW       = 32,
    parameter logic [PCW-1:0] FIQ_VEC   = 32'h0000_0100,
    parameter logic [PCW-1:0] IRQ_VEC   = 32'h0000_0200,
    parameter logic [PCW-1:0] EXC_BASE  = 32'h0000_0400,
    parameter int             EXC_SHIFT = 4,
    localparam int            IRQ_IW    = (NIRQ > 1) ? $clog2(NIRQ) : 1,
    localparam int            EXC_IW    = (NEXC > 1) ? $clog2(NEXC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fiq_req,
    input  logic [NIRQ-1:0]   irq_req,
    input  logic [NEXC-1:0]   exc_src,
    input  logic [NEXC-1:0]   exc_mask,
    input  logic              pipe_drained,
    input  logic [PCW-1:0]    resume_pc,
    input  logic [PCW-1:0]    fault_pc,
    input  logic              host_resume,
    output logic              freeze,
    output logic              busy,
    output logic              redirect_valid,
    output logic [PCW-1:0]    redirect_pc,
    output logic [PCW-1:0]    ret_addr,
    output logic              fiq_ack,
    output logic              irq_ack,
    output logic [IRQ_IW-1:0] irq_id,
    output logic              exc_notify,
    output logic [EXC_IW-1:0] exc_code
);
    iec_state_e        state_q, state_d;
    iec_cause_e        cause_sel, cause_q;
    logic [IRQ_IW-1:0] irq_idx_sel, irq_id_q;
    logic [EXC_IW-1:0] exc_idx_sel, exc_code_q;
    logic              fiq_eff;
    logic [NIRQ-1:0]   irq_eff;
    logic [NEXC-1:0]   exc_eff;
    logic [PCW-1:0]    fault_pc_q;
    logic [PCW-1:0]    target_pc;
    logic              fiq_clr;
    logic [NIRQ-1:0]   irq_clr;
    logic [NEXC-1:0]   exc_clr;
    logic              accept;
    logic              enter_redirect;

    iec_pending #(.NIRQ(NIRQ), .NEXC(NEXC), .PCW(PCW)) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .fiq_req    (fiq_req),
        .irq_req    (irq_req),
        .exc_src    (exc_src),
        .exc_mask   (exc_mask),
        .fault_pc   (fault_pc),
        .fiq_clr    (fiq_clr),
        .irq_clr    (irq_clr),
        .exc_clr    (exc_clr),
        .fiq_eff    (fiq_eff),
        .irq_eff    (irq_eff),
        .exc_eff    (exc_eff),
        .fault_pc_q (fault_pc_q)
    );

    iec_select #(.NIRQ(NIRQ), .NEXC(NEXC), .IRQ_IW(IRQ_IW), .EXC_IW(EXC_IW)) u_select (
        .fiq_eff (fiq_eff),
        .irq_eff (irq_eff),
        .exc_eff (exc_eff),
        .cause   (cause_sel),
        .irq_idx (irq_idx_sel),
        .exc_idx (exc_idx_sel)
    );

    iec_vector #(
        .PCW(PCW), .EXC_IW(EXC_IW), .FIQ_VEC(FIQ_VEC), .IRQ_VEC(IRQ_VEC),
        .EXC_BASE(EXC_BASE), .EXC_SHIFT(EXC_SHIFT)
    ) u_vector (
        .cause   (cause_q),
        .exc_idx (exc_code_q),
        .target  (target_pc)
    );

    assign accept         = (state_q == ST_IDLE) && (cause_sel != CAUSE_NONE);
    assign enter_redirect = (state_q == ST_DRAIN) && pipe_drained;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cause_sel != CAUSE_NONE) state_d = ST_FREEZE;
            ST_FREEZE:   state_d = ST_DRAIN;
            ST_DRAIN:    if (pipe_drained) state_d = ST_REDIRECT;
            ST_REDIRECT: state_d = (cause_q == CAUSE_EXC) ? ST_WAIT_CMD : ST_IDLE;
            ST_WAIT_CMD: if (host_resume) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Entry context: winner captured on accept, return address on redirect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q    <= CAUSE_NONE;
            irq_id_q   <= '0;
            exc_code_q <= '0;
            ret_addr   <= '0;
        end else begin
            if (accept) begin
                cause_q    <= cause_sel;
                irq_id_q   <= irq_idx_sel;
                exc_code_q <= exc_idx_sel;
            end
            if (enter_redirect) begin
                ret_addr <= (cause_q == CAUSE_EXC) ? fault_pc_q : resume_pc;
            end
        end
    end

    // Pending-flag clears
    always_comb begin
        fiq_clr = (state_q == ST_REDIRECT) && (cause_q == CAUSE_FIQ);
        irq_clr = '0;
        exc_clr = '0;
        if ((state_q == ST_REDIRECT) && (cause_q == CAUSE_IRQ)) begin
            irq_clr = NIRQ'(1) << irq_id_q;
        end
        if ((state_q == ST_WAIT_CMD) && host_resume) begin
            exc_clr = NEXC'(1) << exc_code_q;
        end
    end

    // Outputs
    always_comb begin
        freeze         = 1'b0;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        fiq_ack        = 1'b0;
        irq_ack        = 1'b0;
        exc_notify     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_FREEZE, ST_DRAIN, ST_WAIT_CMD: begin
                freeze = 1'b1;
            end
            ST_REDIRECT: begin
                freeze         = 1'b1;
                redirect_valid = 1'b1;
                redirect_pc    = target_pc;
                fiq_ack        = (cause_q == CAUSE_FIQ);
                irq_ack        = (cause_q == CAUSE_IRQ);
                exc_notify     = (cause_q == CAUSE_EXC);
            end
            default: begin
            end
        endcase
        busy = (state_q != ST_IDLE) || (cause_sel != CAUSE_NONE);
    end

    assign irq_id   = irq_id_q;
    assign exc_code = exc_code_q;

    // R11
    redir_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(pipe_drained));

    // R11
    redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    // R6
    freeze_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> freeze);

    // R8
    notify_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_notify |=> (freeze && busy));

    // R2
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fiq_ack, irq_ack, exc_notify}));

    // R7
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !fiq_eff && !(|irq_eff) && !(|exc_eff)) |=> !freeze);
endmodule

// File: tb/intr_exc_ctrl_test.sv
module intr_exc_ctrl_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       fiq;
        logic [3:0] irq;
        logic [3:0] exc;
        logic [3:0] mask;
        logic [1:0] dly;
        logic [1:0] kind;   // 0 none, 1 fast, 2 normal, 3 exception
        logic [1:0] id;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'b0000, 4'b0000, 4'b0000, 2'd0, 2'd1, 2'd0},
        '{1'b0, 4'b0100, 4'b0000, 4'b0000, 2'd0, 2'd2, 2'd2},
        '{1'b0, 4'b0001, 4'b0000, 4'b0000, 2'd2, 2'd2, 2'd0},
        '{1'b0, 4'b0000, 4'b0010, 4'b0000, 2'd0, 2'd3, 2'd1},
        '{1'b0, 4'b0000, 4'b1000, 4'b0000, 2'd3, 2'd3, 2'd3},
        '{1'b0, 4'b0000, 4'b0100, 4'b0100, 2'd0, 2'd0, 2'd0},
        '{1'b0, 4'b0000, 4'b1111, 4'b1111, 2'd0, 2'd0, 2'd0},
        '{1'b1, 4'b0000, 4'b0000, 4'b0000, 2'd1, 2'd1, 2'd0},
        '{1'b0, 4'b1000, 4'b0000, 4'b0000, 2'd1, 2'd2, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fiq_req = 1'b0;
    logic [3:0]  irq_req = '0;
    logic [3:0]  exc_src = '0;
    logic [3:0]  exc_mask = '0;
    logic        pipe_drained = 1'b0;
    logic [31:0] resume_pc = '0;
    logic [31:0] fault_pc = '0;
    logic        host_resume = 1'b0;
    logic        freeze, busy, redirect_valid, fiq_ack, irq_ack, exc_notify;
    logic [31:0] redirect_pc, ret_addr;
    logic [1:0]  irq_id, exc_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    intr_exc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fiq_req(fiq_req), .irq_req(irq_req),
        .exc_src(exc_src), .exc_mask(exc_mask), .pipe_drained(pipe_drained),
        .resume_pc(resume_pc), .fault_pc(fault_pc), .host_resume(host_resume),
        .freeze(freeze), .busy(busy), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .ret_addr(ret_addr), .fiq_ack(fiq_ack),
        .irq_ack(irq_ack), .irq_id(irq_id), .exc_notify(exc_notify),
        .exc_code(exc_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] vec_pc(input logic [1:0] kind, input logic [1:0] id);
        case (kind)
            2'd1:    return 32'h100;
            2'd2:    return 32'h200;
            2'd3:    return 32'h400 + (32'(id) << 4);
            default: return 32'h0;
        endcase
    endfunction

    // Waits at negedges for the next redirect; returns its address, or 0 if none.
    task automatic next_redirect(output logic [31:0] pc);
        bit got = 1'b0;
        pc = 32'h0;
        for (int k = 0; k < 16 && !got; k++) begin
            @(negedge clk);
            if (redirect_valid) begin
                got = 1'b1;
                pc  = redirect_pc;
            end
        end
    endtask

    // Called at the redirect negedge of an exception entry.
    task automatic send_resume();
        @(negedge clk);
        host_resume = 1'b1;
        @(negedge clk);
        host_resume = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog actual=%0d expected=<20000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] pc;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "freeze", 32'(freeze), 0);
        check("R1", "busy", 32'(busy), 0);
        check("R1", "redirect/acks",
              32'({redirect_valid, fiq_ack, irq_ack, exc_notify}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            bit found = 1'b0;
            bit seen_frz = 1'b0;
            fiq_req      = v.fiq;
            irq_req      = v.irq;
            exc_src      = v.exc;
            exc_mask     = v.mask;
            pipe_drained = (v.dly == 2'd0);
            resume_pc    = 32'h1000 + 32'(i) * 4;
            fault_pc     = 32'h2000 + 32'(i) * 4;
            for (int n = 1; n <= 10; n++) begin
                @(negedge clk);
                if (n == 1) begin
                    fiq_req = 1'b0;
                    irq_req = '0;
                    exc_src = '0;
                    if (v.kind != 2'd0) check("R6", "freeze after accept", 32'(freeze), 1);
                end
                if (freeze) seen_frz = 1'b1;
                if (v.dly != 2'd0 && n == 2 + int'(v.dly)) pipe_drained = 1'b1;
                if (redirect_valid && !found) begin
                    found = 1'b1;
                    // R5: latency three cycles plus drain delay
                    check("R5", "latency", 32'(n), 32'(3 + int'(v.dly)));
                    check(v.kind == 2'd3 ? "R8" : (v.kind == 2'd1 ? "R3" : "R4"),
                          "redirect_pc", redirect_pc, vec_pc(v.kind, v.id));
                    // R10: return address source
                    check("R10", "ret_addr", ret_addr,
                          v.kind == 2'd3 ? 32'h2000 + 32'(i) * 4 : 32'h1000 + 32'(i) * 4);
                    check("R3", "fiq_ack", 32'(fiq_ack), 32'(v.kind == 2'd1));
                    check("R4", "irq_ack", 32'(irq_ack), 32'(v.kind == 2'd2));
                    check("R8", "exc_notify", 32'(exc_notify), 32'(v.kind == 2'd3));
                    if (v.kind == 2'd2) check("R4", "irq_id", 32'(irq_id), 32'(v.id));
                    if (v.kind == 2'd3) check("R8", "exc_code", 32'(exc_code), 32'(v.id));
                end
            end
            pipe_drained = 1'b0;
            if (v.kind == 2'd0) begin
                // R7: masked source leaves no trace
                check("R7", "redirect seen", 32'(found), 0);
                check("R7", "freeze seen", 32'(seen_frz), 0);
                check("R7", "busy", 32'(busy), 0);
            end else begin
                check("R11", "redirect seen", 32'(found), 1);
                if (v.kind == 2'd3) begin
                    check("R8", "frozen waiting for command", 32'(freeze), 1);
                    host_resume = 1'b1;
                    @(negedge clk);
                    host_resume = 1'b0;
                    check("R8", "busy after resume", 32'(busy), 0);
                end else begin
                    check("R6", "busy after entry", 32'(busy), 0);
                end
            end
            @(negedge clk);
        end

        pipe_drained = 1'b1;

        // R2: fast beats normal; R9: normal kept and served next
        fiq_req = 1'b1; irq_req = 4'b0001;
        @(negedge clk);
        fiq_req = 1'b0; irq_req = '0;
        next_redirect(pc);
        check("R2", "fast before normal", pc, 32'h100);
        next_redirect(pc);
        check("R9", "held normal served", pc, 32'h200);

        // R2: exception beats fast interrupt
        @(negedge clk);
        fiq_req = 1'b1; exc_src = 4'b0001; fault_pc = 32'h3000;
        @(negedge clk);
        fiq_req = 1'b0; exc_src = '0;
        next_redirect(pc);
        check("R2", "exception first", pc, 32'h400);
        send_resume();
        next_redirect(pc);
        check("R9", "fast after exception", pc, 32'h100);

        // R9: normal request arriving during a fast entry is kept
        @(negedge clk);
        fiq_req = 1'b1;
        @(negedge clk);
        fiq_req = 1'b0; irq_req = 4'b1000;
        @(negedge clk);
        irq_req = '0;
        next_redirect(pc);
        check("R3", "fast entry", pc, 32'h100);
        next_redirect(pc);
        check("R9", "late normal served", pc, 32'h200);
        check("R9", "late normal id", 32'(irq_id), 3);

        // R4: two lines, lowest first, only that one cleared
        @(negedge clk);
        irq_req = 4'b1010;
        @(negedge clk);
        irq_req = '0;
        next_redirect(pc);
        check("R4", "first line id", 32'(irq_id), 1);
        next_redirect(pc);
        check("R4", "second line id", 32'(irq_id), 3);

        // R7: mixed masked and unmasked exception in one cycle
        @(negedge clk);
        exc_src = 4'b0110; exc_mask = 4'b0100;
        @(negedge clk);
        exc_src = '0;
        next_redirect(pc);
        check("R8", "unmasked code", 32'(exc_code), 1);
        send_resume();
        exc_mask = '0;
        begin
            bit act = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (busy || freeze) act = 1'b1;
            end
            check("R7", "masked bit never entered", 32'(act), 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule